// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial EEPROM link. A host raises the select line, clocks in a start bit, a two-bit opcode, an address and, for some commands, a data field, and the block decodes and runs the command against a 2048-byte register array. A width-select input picks byte-wide or word-wide access. Reads stream out a leading zero followed by data, and keep streaming from successive addresses for as long as select stays high.

Commands that change the array run a self-timed programming cycle whose length is a parameter in system clocks. During and after that cycle the serial output can report busy or ready. Programming is locked after reset and must be unlocked by a command. Every serial input is sampled on the system clock and the serial clock is edge-detected, so the host's serial clock must be much slower than the system clock.

Top module: `mw_eeprom`

## Requirements
- R1: After reset serOutEn is 0. While chipSel is high, 0 bits presented on serIn at serClk rises before the first 1 are skipped; the first 1 is taken as the start bit.
- R2: The two bits after the start bit are the opcode: 10 read, 01 write, 11 erase, 00 special. For a special command the two most significant address bits select it: 11 unlock, 00 lock, 01 fill (write-all), 10 clear (erase-all).
- R3: With orgWide 0 the address is 11 bits and data 8 bits; with orgWide 1 the address is 10 bits and data 16 bits. All fields are sent most significant bit first. Word w occupies byte 2w (bits 7:0) and byte 2w+1 (bits 15:8).
- R4: On a read, the serClk rise that carries the last address bit makes serOutEn 1 and serOut 0; each later rise presents the next data bit, most significant first.
- R5: After the last bit of a read word, the next serClk rise presents the first bit of the next higher address, wrapping from the top address to 0, with no further leading zero, until chipSel goes low.
- R6: After reset every byte holds 8'hFF and programming is locked. While locked, write, erase, fill and clear leave the array unchanged. Unlock lasts until a lock command.
- R7: A programming command of correct length while unlocked takes effect at the fall of chipSel and holds the device busy for PROG_CYCLES clocks; a start bit sent while busy is ignored and the command it heads has no effect.
- R8: When chipSel is raised with a programming status pending, serOutEn is 1 and serOut is 0 while busy and 1 once the cycle has ended.
- R9: Pending status is cleared by a serClk rise with chipSel and serIn high, or by chipSel being low when the cycle is over; a cycle that ends while chipSel is low is never reported.
- R10: If the bits after the start bit do not number exactly 2 plus the address width (plus the data width for write and fill), write, erase, fill, clear, unlock and lock are all rejected; a read is still carried out.
- R11: Erase sets the addressed byte or word to all ones, clear sets the whole array to all ones, and fill writes the given pattern into every location.
- R12: serOutEn is 0 whenever the sampled chipSel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| chipSel | input | 1 | Select; high frames a command |
| serClk | input | 1 | Serial clock from the host, sampled on clk |
| serIn | input | 1 | Serial command, address and data input |
| orgWide | input | 1 | 0 byte-wide, 1 word-wide access |
| serOut | output | 1 | Serial read data or ready/busy status |
| serOutEn | output | 1 | Drive enable for serOut |

## Verification
Each input passes one sampling register and a serClk rise is acted upon on the second system clock after the pin changes, so a read bit or the leading zero is valid two clocks after serClk rises; the bench holds serClk high for four clocks and samples serOut on the falling clk edge at the end of that phase. A command's effect on the array appears two clocks after chipSel falls, and busy lasts PROG_CYCLES clocks from there, so the bench probes status four clocks after raising chipSel (well inside the cycle) and again PROG_CYCLES plus ten clocks later. Array contents are checked only through later read commands against a byte model kept in the bench.

// File: rtl/mw_ee_pkg.sv
`timescale 1ns/1ps
package mw_ee_pkg;
  localparam int unsigned EE_BYTES = 2048;
  localparam int unsigned EE_AB    = $clog2(EE_BYTES);  // byte address width
  localparam int unsigned EE_AW    = EE_AB - 1;         // word address width
  localparam int unsigned EE_DW    = 16;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_READ} ctlState_e;

  typedef struct packed {
    logic             wrOne;
    logic             wrAll;
    logic [EE_AB-1:0] wrAddr;
    logic [EE_DW-1:0] wrData;
    logic             rdLoad;
    logic             rdStep;
    logic [EE_AB-1:0] rdAddr;
  } eeStrobe_t;
endpackage

// File: rtl/mw_ee_array.sv
`timescale 1ns/1ps
module mw_ee_array
  import mw_ee_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             orgWide,
  input  eeStrobe_t        strb,
  output logic [EE_DW-1:0] rdData
);
  logic [7:0]       mem [EE_BYTES];
  logic [EE_AB-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < EE_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < EE_BYTES; i++) begin
        if (strb.wrAll) begin
          mem[i] <= (orgWide && i[0]) ? strb.wrData[15:8] : strb.wrData[7:0];
        end else if (strb.wrOne) begin
          if (orgWide) begin
            if (EE_AW'(i >> 1) == strb.wrAddr[EE_AW-1:0])
              mem[i] <= i[0] ? strb.wrData[15:8] : strb.wrData[7:0];
          end else if (EE_AB'(i) == strb.wrAddr) begin
            mem[i] <= strb.wrData[7:0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdPtr <= '0;
    else if (strb.rdLoad) rdPtr <= strb.rdAddr;
    else if (strb.rdStep) rdPtr <= orgWide ? {1'b0, rdPtr[EE_AW-1:0] + 1'b1} : rdPtr + 1'b1;
  end

  always_comb begin
    if (orgWide) rdData = {mem[{rdPtr[EE_AW-1:0], 1'b1}], mem[{rdPtr[EE_AW-1:0], 1'b0}]};
    else         rdData = {mem[rdPtr], 8'h00};
  end

  // R5: word-mode address wraps from the top word to word 0
  a_r5_word_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStep && orgWide && (&rdPtr[EE_AW-1:0])) |=> (rdPtr[EE_AW-1:0] == '0));
endmodule

// File: rtl/mw_ee_ctrl.sv
`timescale 1ns/1ps
module mw_ee_ctrl
  import mw_ee_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 64
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             serClk,
  input  logic             serIn,
  input  logic             orgWide,
  input  logic [EE_DW-1:0] rdData,
  output eeStrobe_t        strb,
  output logic             serOut,
  output logic             serOutEn
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  localparam logic [5:0] AW_BYTE = 6'(EE_AB);
  localparam logic [5:0] AW_WORD = 6'(EE_AW);

  logic csQ, csQ2, skQ, skQ2, diQ;
  logic skRise, csFall, shiftEdge;
  ctlState_e state;
  logic [5:0] bitCnt, aw, dw, needLen;
  logic [1:0] opReg, subOp;
  logic [EE_AB-1:0] addrReg;
  logic [EE_DW-1:0] dataReg, progData, rdShift;
  logic [3:0] rdCnt, rdLast;
  logic wrEnable, busy, statusArmed, statusShow, doutBit;
  logic [CW-1:0] busyCnt;
  logic lenOk, isProg, progAll, execNow, progGo, readHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {csQ, csQ2, skQ, skQ2, diQ} <= '0;
    else       {csQ, csQ2, skQ, skQ2, diQ} <= {chipSel, csQ, serClk, skQ, serIn};
  end

  assign skRise    = skQ & ~skQ2;
  assign csFall    = csQ2 & ~csQ;
  assign shiftEdge = skRise & csQ;
  assign aw        = orgWide ? AW_WORD : AW_BYTE;
  assign dw        = orgWide ? 6'd16 : 6'd8;
  assign rdLast    = orgWide ? 4'd15 : 4'd7;
  assign subOp     = orgWide ? addrReg[EE_AW-1 -: 2] : addrReg[EE_AB-1 -: 2];

  always_comb begin
    needLen  = 6'd2 + aw;
    isProg   = 1'b0;
    progAll  = 1'b0;
    progData = '1;
    case (opReg)
      OP_WRITE: begin
        isProg   = 1'b1;
        needLen  = 6'd2 + aw + dw;
        progData = orgWide ? dataReg : {8'h00, dataReg[7:0]};
      end
      OP_ERASE: isProg = 1'b1;
      OP_SPECIAL: begin
        if (subOp == SUB_FILL) begin
          isProg   = 1'b1;
          progAll  = 1'b1;
          needLen  = 6'd2 + aw + dw;
          progData = orgWide ? dataReg : {8'h00, dataReg[7:0]};
        end else if (subOp == SUB_CLEAR) begin
          isProg  = 1'b1;
          progAll = 1'b1;
        end
      end
      default: ;
    endcase
    lenOk   = (bitCnt == needLen);
    execNow = csFall && (state == ST_SHIFT) && lenOk;
    progGo  = execNow && isProg && wrEnable && !busy;
    readHit = shiftEdge && (state == ST_SHIFT) && (opReg == OP_READ) && (bitCnt == 6'd1 + aw);

    strb.wrOne  = progGo && !progAll;
    strb.wrAll  = progGo && progAll;
    strb.wrAddr = addrReg;
    strb.wrData = progData;
    strb.rdLoad = readHit;
    strb.rdStep = shiftEdge && (state == ST_READ) && (rdCnt == rdLast);
    strb.rdAddr = {addrReg[EE_AB-2:0], diQ};
  end

  // serial framing and read streaming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      opReg   <= '0;
      addrReg <= '0;
      dataReg <= '0;
      rdCnt   <= '0;
      rdShift <= '0;
      doutBit <= 1'b0;
    end else if (csFall) begin
      state <= ST_IDLE;
    end else if (shiftEdge) begin
      case (state)
        ST_IDLE: if (diQ && !busy) begin
          state   <= ST_SHIFT;
          bitCnt  <= '0;
          opReg   <= '0;
          addrReg <= '0;
          dataReg <= '0;
        end
        ST_SHIFT: begin
          if (bitCnt < 6'd2)             opReg   <= {opReg[0], diQ};
          else if (bitCnt < 6'd2 + aw)   addrReg <= {addrReg[EE_AB-2:0], diQ};
          else if (bitCnt < needLen)     dataReg <= {dataReg[EE_DW-2:0], diQ};
          if (bitCnt != 6'h3F) bitCnt <= bitCnt + 6'd1;
          if (readHit) begin
            state   <= ST_READ;
            doutBit <= 1'b0;
            rdCnt   <= '0;
          end
        end
        ST_READ: begin
          if (rdCnt == 4'd0) begin
            doutBit <= rdData[EE_DW-1];
            rdShift <= {rdData[EE_DW-2:0], 1'b0};
          end else begin
            doutBit <= rdShift[EE_DW-1];
            rdShift <= {rdShift[EE_DW-2:0], 1'b0};
          end
          rdCnt <= (rdCnt == rdLast) ? 4'd0 : rdCnt + 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // write lock, programming timer, pending status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnable    <= 1'b0;
      busy        <= 1'b0;
      busyCnt     <= '0;
      statusArmed <= 1'b0;
    end else begin
      if (execNow && opReg == OP_SPECIAL && subOp == SUB_UNLOCK) wrEnable <= 1'b1;
      if (execNow && opReg == OP_SPECIAL && subOp == SUB_LOCK)   wrEnable <= 1'b0;
      if (progGo) begin
        busy    <= 1'b1;
        busyCnt <= CW'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else               busyCnt <= busyCnt - 1'b1;
      end
      if (progGo)                                 statusArmed <= 1'b1;
      else if ((shiftEdge && diQ) || (!csQ && !busy)) statusArmed <= 1'b0;
    end
  end

  assign statusShow = statusArmed & csQ;
  assign serOut     = statusShow ? ~busy : doutBit;
  assign serOutEn   = csQ & (statusShow | (state == ST_READ));

  // ---- assertions ----
  logic [31:0] busyAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyAge <= '0;
    else if (busy) busyAge <= busyAge + 1;
    else           busyAge <= '0;
  end

  // R7: busy lasts exactly PROG_CYCLES clocks
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyAge == PROG_CYCLES));
  // R7: no command framing starts while busy
  a_r7_idle_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && busy && !csFall) |=> (state == ST_IDLE));
  // R6: array strobes only when unlocked
  a_r6_prog_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrOne || strb.wrAll) |-> wrEnable);
  // R11: at most one kind of array action per clock
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOne, strb.wrAll, strb.rdLoad, strb.rdStep}));
  // R4: entering read drives the leading zero
  a_r4_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_READ) |-> (doutBit == 1'b0));
  // R12: no drive without select
  a_r12_oe_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!csQ && !csQ2) |-> !serOutEn);
endmodule

// File: rtl/mw_eeprom.sv
`timescale 1ns/1ps
module mw_eeprom
  import mw_ee_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 64
)(
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  input  logic orgWide,
  output logic serOut,
  output logic serOutEn
);
  eeStrobe_t        strb;
  logic [EE_DW-1:0] rdData;

  mw_ee_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .orgWide(orgWide), .rdData(rdData), .strb(strb), .serOut(serOut), .serOutEn(serOutEn)
  );

  mw_ee_array u_array (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .strb(strb), .rdData(rdData)
  );
endmodule

// File: tb/mw_eeprom_tb.sv
`timescale 1ns/1ps
module mw_eeprom_tb;
  localparam int PROG = 400;

  logic clk = 1'b0, rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0, orgWide = 1'b0;
  logic serOut, serOutEn;
  logic sampOut, sampEn;
  int total = 0, bad = 0;
  logic [7:0] refMem [2048];

  always #4 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .orgWide(orgWide), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic csUp();   chipSel = 1'b1; tick(4); endtask
  task automatic csDown(); chipSel = 1'b0; tick(4); endtask

  task automatic clkBit(input logic b);
    serIn = b; tick(4);
    serClk = 1'b1; tick(4);
    sampOut = serOut; sampEn = serOutEn;
    serClk = 1'b0;
  endtask

  task automatic sendField(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) clkBit(v[k]);
  endtask

  function automatic int awNow(); return orgWide ? 10 : 11; endfunction
  function automatic int dwNow(); return orgWide ? 16 : 8;  endfunction

  // frame a command; leaves chipSel low afterwards
  task automatic sendCmd(input logic [1:0] op, input logic [31:0] addr,
                         input logic [31:0] data, input int nData, input int extra);
    csUp();
    clkBit(1'b1);
    sendField({30'd0, op}, 2);
    sendField(addr, awNow());
    if (nData > 0) sendField(data, nData);
    for (int k = 0; k < extra; k++) clkBit(1'b0);
    csDown();
  endtask

  function automatic logic [31:0] special(input logic [1:0] sub);
    return {30'd0, sub} << (awNow() - 2);
  endfunction

  function automatic logic [15:0] refWord(input int a);
    if (orgWide) return {refMem[2*a+1], refMem[2*a]};
    return {8'h00, refMem[a]};
  endfunction

  task automatic readCheck(input int addr, input int nWords, input int lead, input string tag);
    int a;
    logic [15:0] got;
    a = addr;
    csUp();
    for (int k = 0; k < lead; k++) clkBit(1'b0);
    clkBit(1'b1);
    sendField(32'd2, 2);
    sendField(addr, awNow());
    chk(sampEn === 1'b1 && sampOut === 1'b0, {tag, " R4 leading zero"}, {sampEn, sampOut}, 2);
    for (int w = 0; w < nWords; w++) begin
      got = '0;
      for (int b = 0; b < dwNow(); b++) begin
        clkBit(1'b0);
        got = {got[14:0], sampOut};
      end
      chk(got == refWord(a), tag, got, refWord(a));
      a = (a + 1) % (orgWide ? 1024 : 2048);
    end
    csDown();
  endtask

  task automatic progWait(); tick(PROG + 10); endtask

  initial begin
    tick(500000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, d;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 2048; i++) refMem[i] = 8'hFF;
    tick(3);
    chk(serOutEn === 1'b0, "R1 output off after reset", serOutEn, 0);
    rstN = 1'b1; tick(3);

    // R6: locked after reset, array all ones
    readCheck(5, 1, 0, "R6 reset contents");
    sendCmd(2'b01, 5, 8'h5A, 8, 0); progWait();
    readCheck(5, 1, 0, "R6 write while locked");

    // R10: unlock with a trailing extra bit is rejected
    sendCmd(2'b00, special(2'b11), 0, 0, 1); progWait();
    sendCmd(2'b01, 5, 8'h5A, 8, 0); progWait();
    readCheck(5, 1, 0, "R10 bad-length unlock");

    // R2: proper unlock
    sendCmd(2'b00, special(2'b11), 0, 0, 0);
    // R10: write with an extra bit rejected
    sendCmd(2'b01, 5, 8'h5A, 8, 1); progWait();
    readCheck(5, 1, 0, "R10 bad-length write");

    // R7/R8/R9: status while busy, then ready, then cleared
    sendCmd(2'b01, 5, 8'h5A, 8, 0);
    refMem[5] = 8'h5A;
    csUp();
    chk(serOutEn === 1'b1 && serOut === 1'b0, "R8 busy status", {serOutEn, serOut}, 2);
    tick(PROG + 10);
    chk(serOutEn === 1'b1 && serOut === 1'b1, "R8 ready status", {serOutEn, serOut}, 3);
    clkBit(1'b1);
    chk(sampEn === 1'b0, "R9 status cleared by start bit", sampEn, 0);
    csDown();
    chk(serOutEn === 1'b0, "R12 no drive with select low", serOutEn, 0);
    readCheck(5, 1, 0, "R2 write then read");

    // R1: leading zeros before start bit
    readCheck(5, 1, 3, "R1 leading zeros skipped");

    // R9: cycle finishing with select low is not reported
    sendCmd(2'b01, 7, 8'hC3, 8, 0);
    refMem[7] = 8'hC3;
    progWait();
    csUp();
    chk(serOutEn === 1'b0, "R9 late status hidden", serOutEn, 0);
    csDown();

    // R7: a command sent while busy is ignored
    sendCmd(2'b01, 9, 8'h33, 8, 0);
    refMem[9] = 8'h33;
    sendCmd(2'b01, 10, 8'h44, 8, 0);
    progWait();
    readCheck(9, 2, 0, "R7 second command ignored");

    // R11: erase a byte
    sendCmd(2'b11, 5, 0, 0, 0); progWait();
    refMem[5] = 8'hFF;
    readCheck(5, 1, 0, "R11 erase byte");

    // R4/R5: random writes, sequential reads
    for (int it = 0; it < 20; it++) begin
      a = $urandom_range(0, 2046);
      d = $urandom_range(0, 255);
      sendCmd(2'b01, a, d, 8, 0); progWait();
      refMem[a] = 8'(d);
      readCheck(a, 2, 0, "R4 random byte read");
    end

    // R5: byte-mode wrap
    sendCmd(2'b01, 2047, 8'h11, 8, 0); progWait(); refMem[2047] = 8'h11;
    sendCmd(2'b01, 0, 8'h22, 8, 0); progWait(); refMem[0] = 8'h22;
    readCheck(2046, 4, 0, "R5 byte wrap");

    // R3: word mode write and byte view
    orgWide = 1'b1;
    sendCmd(2'b01, 3, 16'hBEEF, 16, 0); progWait();
    refMem[6] = 8'hEF; refMem[7] = 8'hBE;
    readCheck(3, 1, 0, "R3 word read");
    sendCmd(2'b01, 1023, 16'h1234, 16, 0); progWait();
    refMem[2046] = 8'h34; refMem[2047] = 8'h12;
    readCheck(1023, 2, 0, "R5 word wrap");
    orgWide = 1'b0;
    readCheck(6, 2, 0, "R3 byte view of word");

    // R11: fill and clear
    sendCmd(2'b00, special(2'b01), 8'h3C, 8, 0); progWait();
    for (int i = 0; i < 2048; i++) refMem[i] = 8'h3C;
    readCheck(100, 3, 0, "R11 fill");
    sendCmd(2'b00, special(2'b10), 0, 0, 0); progWait();
    for (int i = 0; i < 2048; i++) refMem[i] = 8'hFF;
    readCheck(1500, 2, 0, "R11 clear");

    // R6: lock again and try a write
    sendCmd(2'b00, special(2'b00), 0, 0, 0);
    sendCmd(2'b01, 20, 8'h00, 8, 0); progWait();
    readCheck(20, 1, 0, "R6 locked again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule